// File: doc/BRIEF.md
# Dual BCD Decade Ripple Counter

This block holds a set of independent decimal counting sections. There are two by default. Each section counts 0 through 9 in 8-4-2-1 binary-coded decimal and advances on the high-to-low transition of its own clock. After 9 it returns to 0. Each section also has two asynchronous control inputs. The clear input forces the digit to 0000. The preset input forces the digit to 1001 (nine). Neither control waits for a clock edge.

A section is a ripple chain, not a synchronous binary counter. A single toggle flop makes the least significant bit and divides its clock by two. Its output, on its own falling edge, clocks a three-bit divide-by-five stage, and that stage supplies bits 3..1. The upper stage treats any unused state as its last state, so it returns to zero on its next clock.

Use the block where a decimal digit count is needed per clock domain. A typical case is a divider or a digit display driven by a slow or gated clock, where a preset to nine lets the next falling edge roll over to zero.

Top module: `dual_decade_counter`

## Requirements
- R1: A section's digit does not change on a rising edge of its clock input; it advances only on a falling edge.
- R2: With clear and preset both low, each falling clock edge moves the digit through 0,1,...,9 in 8-4-2-1 BCD, and the edge after 9 gives 0.
- R3: Raising the clear input forces the digit to 0000 at once, with no clock edge. This holds for a pulse that starts and ends between two clock edges.
- R4: Raising the preset input forces the digit to 1001 at once, with no clock edge. This holds for a pulse between two clock edges.
- R5: With the default priority setting, preset wins when clear and preset are both high, and the digit reads 1001.
- R6: While clear or preset is held high, falling clock edges leave the digit at its forced value. Counting resumes from that value on the first falling edge after both are low.
- R7: Sections are independent. The clock, clear and preset of one section never change another section's digit.
- R8: On each counting falling edge, bit 0 toggles. Bits 3..1 change only on an edge where bit 0 goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | N_SECT | Per-section count clock; bit s clocks section s on its falling edge |
| mrst_i | input | N_SECT | Per-section asynchronous clear to 0000, active high |
| mset_i | input | N_SECT | Per-section asynchronous preset to 1001, active high |
| count_o | output | 4*N_SECT | Section s digit in bits 4s+3..4s, 8-4-2-1 BCD |

## Verification
The assertions sample on each section's falling clock edge. They assume that a clear or preset edge never lands on the same instant as a falling clock edge. They also assume that preset is never released while clear stays high: the flops react only to edges, so clear is not reapplied after such a release. The stimulus keeps to both rules. It changes clear and preset only in the last quarter of the bench clock period, which lies between the falling edges of both sections. It always lowers a held pair together. Short pulses rise and fall inside that same gap, so the forced value is seen only at the ports before the next edge.

// File: rtl/dcnt_pkg.sv
`timescale 1ns/100ps
package dcnt_pkg;
   localparam int unsigned DIGIT_W = 4;
   localparam int unsigned UPPER_W = DIGIT_W - 1;
   localparam logic [DIGIT_W-1:0] DIGIT_PRESET = 4'd9;
   localparam logic [UPPER_W-1:0] QUIN_LAST = 3'd4;

   typedef logic [DIGIT_W-1:0] digit_t;
   typedef logic [UPPER_W-1:0] quin_t;

   // next state of the divide-by-five stage; any code at or above the
   // last legal one returns to zero so unused states cannot persist
   function automatic quin_t quin_step(input quin_t cur);
      return (cur >= QUIN_LAST) ? '0 : cur + quin_t'(1);
   endfunction
endpackage

// File: rtl/dcnt_lsb_stage.sv
`timescale 1ns/100ps
module dcnt_lsb_stage #(
   parameter bit SET_WINS = 1'b1,
   parameter bit PRESET_BIT = 1'b1
) (
   input  logic clk_fall_i,
   input  logic clr_i,
   input  logic pre_i,
   output logic q_o
);
   generate
      if (SET_WINS) begin : g_pre_first
         always_ff @(negedge clk_fall_i or posedge clr_i or posedge pre_i) begin
            if (pre_i)      q_o <= PRESET_BIT;
            else if (clr_i) q_o <= 1'b0;
            else            q_o <= ~q_o;
         end
      end else begin : g_clr_first
         always_ff @(negedge clk_fall_i or posedge clr_i or posedge pre_i) begin
            if (clr_i)      q_o <= 1'b0;
            else if (pre_i) q_o <= PRESET_BIT;
            else            q_o <= ~q_o;
         end
      end
   endgenerate
endmodule

// File: rtl/dcnt_quin_stage.sv
`timescale 1ns/100ps
module dcnt_quin_stage
   import dcnt_pkg::*;
#(
   parameter bit SET_WINS = 1'b1,
   parameter quin_t PRESET_VAL = DIGIT_PRESET[DIGIT_W-1:1]
) (
   input  logic  clk_fall_i,
   input  logic  clr_i,
   input  logic  pre_i,
   output quin_t q_o
);
   generate
      if (SET_WINS) begin : g_pre_first
         always_ff @(negedge clk_fall_i or posedge clr_i or posedge pre_i) begin
            if (pre_i)      q_o <= PRESET_VAL;
            else if (clr_i) q_o <= '0;
            else            q_o <= quin_step(q_o);
         end
      end else begin : g_clr_first
         always_ff @(negedge clk_fall_i or posedge clr_i or posedge pre_i) begin
            if (clr_i)      q_o <= '0;
            else if (pre_i) q_o <= PRESET_VAL;
            else            q_o <= quin_step(q_o);
         end
      end
   endgenerate
endmodule

// File: rtl/dcnt_section.sv
`timescale 1ns/100ps
module dcnt_section
   import dcnt_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic   clk_i,
   input  logic   mrst_i,
   input  logic   mset_i,
   output digit_t count_o
);
   logic  lsb_q;
   quin_t upper_q;

   dcnt_lsb_stage #(
      .SET_WINS  (SET_WINS),
      .PRESET_BIT(DIGIT_PRESET[0])
   ) u_lsb (
      .clk_fall_i(clk_i),
      .clr_i     (mrst_i),
      .pre_i     (mset_i),
      .q_o       (lsb_q)
   );

   // upper stages ripple from the falling edge of bit 0
   dcnt_quin_stage #(
      .SET_WINS  (SET_WINS),
      .PRESET_VAL(DIGIT_PRESET[DIGIT_W-1:1])
   ) u_upper (
      .clk_fall_i(lsb_q),
      .clr_i     (mrst_i),
      .pre_i     (mset_i),
      .q_o       (upper_q)
   );

   assign count_o = {upper_q, lsb_q};
endmodule

// File: rtl/dual_decade_counter.sv
`timescale 1ns/100ps
module dual_decade_counter
   import dcnt_pkg::*;
#(
   parameter int unsigned N_SECT = 2,
   parameter bit SET_WINS = 1'b1
) (
   input  logic [N_SECT-1:0]         clk_i,
   input  logic [N_SECT-1:0]         mrst_i,
   input  logic [N_SECT-1:0]         mset_i,
   output logic [N_SECT*DIGIT_W-1:0] count_o
);
   localparam int unsigned CNT_W = N_SECT * DIGIT_W;

   generate
      if (N_SECT < 1 || N_SECT > 64) begin : g_bad_sect
         $error("dual_decade_counter: N_SECT must lie in 1..64");
      end
      if (CNT_W != $bits(count_o)) begin : g_bad_width
         $error("dual_decade_counter: output width mismatch");
      end
      for (genvar g = 0; g < N_SECT; g++) begin : g_sect
         dcnt_section #(
            .SET_WINS(SET_WINS)
         ) u_sect (
            .clk_i  (clk_i[g]),
            .mrst_i (mrst_i[g]),
            .mset_i (mset_i[g]),
            .count_o(count_o[g*DIGIT_W +: DIGIT_W])
         );
      end
   endgenerate
endmodule

// File: rtl/dcnt_checker.sv
`timescale 1ns/100ps
module dcnt_checker #(
   parameter int unsigned N_SECT = 2,
   parameter bit SET_WINS = 1'b1
) (
   input logic [N_SECT-1:0]   clk_i,
   input logic [N_SECT-1:0]   mrst_i,
   input logic [N_SECT-1:0]   mset_i,
   input logic [N_SECT*4-1:0] count_o
);
   function automatic logic [3:0] dec_next(input logic [3:0] c);
      return (c == 4'd9) ? 4'd0 : c + 4'd1;
   endfunction

   generate
      for (genvar s = 0; s < N_SECT; s++) begin : g_chk
         logic [3:0] cnt;
         logic       frc;
         logic       clr_eff;
         logic       pre_eff;
         bit         armed;
         bit [7:0]   fcnt;

         assign cnt     = count_o[4*s +: 4];
         assign frc     = mrst_i[s] | mset_i[s];
         assign clr_eff = SET_WINS ? (mrst_i[s] & ~mset_i[s]) : mrst_i[s];
         assign pre_eff = SET_WINS ? mset_i[s] : (mset_i[s] & ~mrst_i[s]);

         // counts every clear/preset onset so forced intervals are seen
         always_ff @(posedge frc) begin
            armed <= 1'b1;
            fcnt  <= fcnt + 8'd1;
         end

         p_clear_zero_r3: assert property (@(negedge clk_i[s]) disable iff (!armed)
            clr_eff |-> cnt == 4'd0)
            else $error("R3: clear held but digit %0d", cnt);

         p_preset_nine_r4: assert property (@(negedge clk_i[s]) disable iff (!armed)
            pre_eff |-> cnt == 4'd9)
            else $error("R4: preset held but digit %0d", cnt);

         if (SET_WINS) begin : g_prio
            p_preset_wins_r5: assert property (@(negedge clk_i[s]) disable iff (!armed)
               (mrst_i[s] && mset_i[s]) |-> cnt == 4'd9)
               else $error("R5: both forced, digit %0d", cnt);
         end

         p_step_r2: assert property (@(negedge clk_i[s]) disable iff (!armed || frc)
            (!$past(frc) && $past(fcnt) == fcnt) |-> cnt == dec_next($past(cnt)))
            else $error("R2: bad successor %0d", cnt);

         p_lsb_toggle_r8: assert property (@(negedge clk_i[s]) disable iff (!armed || frc)
            (!$past(frc) && $past(fcnt) == fcnt) |-> cnt[0] != $past(cnt[0]))
            else $error("R8: bit 0 did not toggle");

         p_upper_hold_r8: assert property (@(negedge clk_i[s]) disable iff (!armed || frc)
            (!$past(frc) && $past(fcnt) == fcnt && !$past(cnt[0]))
               |-> cnt[3:1] == $past(cnt[3:1]))
            else $error("R8: upper bits moved without bit 0 falling");
      end
   endgenerate
endmodule

bind dual_decade_counter dcnt_checker #(
   .N_SECT  (N_SECT),
   .SET_WINS(SET_WINS)
) u_dcnt_chk (
   .clk_i  (clk_i),
   .mrst_i (mrst_i),
   .mset_i (mset_i),
   .count_o(count_o)
);

// File: tb/dual_decade_counter_tb.sv
`timescale 1ns/100ps
module dual_decade_counter_tb;
   logic       tb_clk = 1'b0;
   logic       clk1   = 1'b0;
   logic [1:0] mrst   = 2'b00;
   logic [1:0] mset   = 2'b00;
   logic [7:0] count;
   logic [3:0] m0, m1;
   int         n_chk  = 0;
   int         n_fail = 0;
   bit         done   = 1'b0;
   bit [1:0]   quiet  = 2'b00;
   logic [3:0] prev_a0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 tb_clk = ~tb_clk;                 // 250 MHz
   always @(posedge tb_clk) clk1 <= ~clk1;     // section 1 at half rate

   dual_decade_counter u_dut (
      .clk_i  ({clk1, tb_clk}),
      .mrst_i (mrst),
      .mset_i (mset),
      .count_o(count)
   );

   // reference digits: modulo-10 count, forced values from the requirements
   always @(negedge tb_clk or posedge mrst[0] or posedge mset[0]) begin
      if (mset[0])      m0 <= 4'd9;
      else if (mrst[0]) m0 <= 4'd0;
      else              m0 <= (m0 == 4'd9) ? 4'd0 : m0 + 4'd1;
   end
   always @(negedge clk1 or posedge mrst[1] or posedge mset[1]) begin
      if (mset[1])      m1 <= 4'd9;
      else if (mrst[1]) m1 <= 4'd0;
      else              m1 <= (m1 == 4'd9) ? 4'd0 : m1 + 4'd1;
   end

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
      end
   endtask

   // one bench period: sample after the rise, after the fall, then drive
   task automatic run_cycle(input logic [1:0] nr, input logic [1:0] ns, input logic [1:0] pl);
      @(posedge tb_clk); #1;
      check("R2 sec0", count[3:0], m0);
      check("R7 sec1", count[7:4], m1);
      if (quiet[0]) check("R1 rise", count[3:0], prev_a0);
      @(negedge tb_clk); #1;
      check("R2 sec0", count[3:0], m0);
      check("R7 sec1", count[7:4], m1);
      if (quiet[0]) begin
         check("R8 bit0", {3'b0, count[0]}, {3'b0, ~prev_a0[0]});
         if (!prev_a0[0]) check("R8 upper", {1'b0, count[3:1]}, {1'b0, prev_a0[3:1]});
      end
      prev_a0 = count[3:0];
      for (int s = 0; s < 2; s++) quiet[s] = !(mrst[s] | mset[s] | nr[s] | ns[s]);
      #0.5;
      mrst = nr;
      mset = ns;
      if (pl != 2'b00) begin
         #0.3;
         mrst = mrst & ~pl;
         mset = mset & ~pl;
      end
   endtask

   initial begin
      #1 mrst = 2'b11;
      #2;
      check("R3 reset sec0", count[3:0], 4'd0);
      check("R3 reset sec1", count[7:4], 4'd0);
      for (int i = 0; i < 3; i++) run_cycle(2'b11, 2'b00, 2'b00);
      check("R6 held clear sec0", count[3:0], 4'd0);
      check("R6 held clear sec1", count[7:4], 4'd0);
      run_cycle(2'b00, 2'b00, 2'b00);
      for (int i = 0; i < 12; i++) run_cycle(2'b00, 2'b00, 2'b00);
      check("R2 twelve falls", count[3:0], 4'd2);
      check("R7 six falls", count[7:4], 4'd6);
      // preset pulse on section 0 between edges
      run_cycle(2'b00, 2'b01, 2'b01);
      #0.1;
      check("R4 preset pulse", count[3:0], 4'd9);
      check("R7 sec1 untouched", count[7:4], m1);
      run_cycle(2'b00, 2'b00, 2'b00);
      #0.1;
      check("R2 wrap after nine", count[3:0], 4'd0);
      // both held on section 0
      run_cycle(2'b01, 2'b01, 2'b00);
      run_cycle(2'b01, 2'b01, 2'b00);
      check("R5 preset wins", count[3:0], 4'd9);
      run_cycle(2'b00, 2'b00, 2'b00);
      check("R6 held value after release", count[3:0], 4'd9);
      run_cycle(2'b00, 2'b00, 2'b00);
      check("R6 resume from nine", count[3:0], 4'd0);
      // clear pulse on section 1
      run_cycle(2'b10, 2'b00, 2'b10);
      #0.1;
      check("R3 clear pulse sec1", count[7:4], 4'd0);
      // random clear/preset activity
      for (int i = 0; i < 400; i++) begin
         logic [1:0] nr, ns, pl;
         nr = 2'b00; ns = 2'b00; pl = 2'b00;
         for (int k = 0; k < 5; k++)
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         for (int s = 0; s < 2; s++) begin
            if (mrst[s] | mset[s]) begin
               if (!lfsr[s]) begin
                  nr[s] = mrst[s];
                  ns[s] = mset[s] | lfsr[2+s];
               end
            end else if (lfsr[4*s+6 +: 3] == 3'b000) begin
               case (lfsr[8+2*s +: 2])
                  2'd1:    ns[s] = 1'b1;
                  2'd2:    begin nr[s] = 1'b1; ns[s] = 1'b1; end
                  default: nr[s] = 1'b1;
               endcase
               pl[s] = lfsr[14+s];
            end
         end
         run_cycle(nr, ns, pl);
      end
      run_cycle(2'b00, 2'b00, 2'b00);
      run_cycle(2'b00, 2'b00, 2'b00);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 watchdog: actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule